// File: doc/BRIEF.md
# GPIO Controller with Sampled Inputs and Level Interrupts

A memory-mapped controller for a bank of general-purpose pins. Software reaches it through a 32-bit single-cycle-acknowledge bus slave in the Wishbone style. The controller drives each pin from a stored output value or, pin by pin, from an auxiliary source. It presents an active-low output enable per pin. It captures the pin levels into a readable input register.

Input capture runs on every bus clock by default. Software can switch capture to one selected edge of an external sampling clock. That clock is asynchronous to the bus: it passes through a two-stage synchroniser and is edge-detected in the bus domain. Each pin can raise a level-sensitive interrupt. The pin's own enable and polarity bits set the trigger, and a global enable gates all pins. A pending flag records the event and drives the request line until software clears it.

Top module: `gpio_port`

## Requirements
- R1: The word index sits in address bits [ADDR_SHIFT+2:ADDR_SHIFT] (default ADDR_SHIFT=2). The indices are: 0 = sampled input (read-only), 1 = output value, 2 = output enable, 3 = interrupt enable, 4 = interrupt polarity, 5 = auxiliary select, 6 = control. Index 7 reads zero. Register bits at and above N_PINS read zero.
- R2: Every strobed access (cyc_i and stb_i high) is acknowledged in the following cycle, for one cycle. Read data is valid while ack_o is high.
- R3: A write takes effect only when all four bits of sel_i are set. A write with any other byte-enable pattern leaves the addressed register unchanged.
- R4: With control bit 0 (external capture) clear, the input register loads the pins on every bus clock. A pin change is readable within two bus clocks.
- R5: With control bit 0 set and control bit 1 (falling select) clear, the input register loads only on a synchronised rising edge of ext_clk_i. Pin changes at any other time leave it unchanged.
- R6: With control bits 0 and 1 both set, the input register loads only on a synchronised falling edge of ext_clk_i. A rising edge leaves it unchanged.
- R7: pin_oe_no is the bitwise complement of the output enable register.
- R8: For each pin, pin_o equals aux_i where the auxiliary select bit is 1, and the output value bit where it is 0.
- R9: A pin triggers when its interrupt enable bit is 1 and its sampled level equals its polarity bit (1 = high, 0 = low). While control bit 2 (global enable) is set, a trigger sets control bit 3 (pending). irq_o follows bit 3 and rises within two bus clocks of the pin change.
- R10: A control write with bit 3 at 0 clears the pending flag at that write. This holds even if a trigger is active in the same cycle. If the trigger is still present and enabled, the flag sets again one cycle later. Writing 1 to bit 3 cannot set the flag.
- R11: irq_o never rises while the global interrupt enable is clear.
- R12: After reset every register is zero. All pin_oe_no bits are high, pin_o is zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | Write when high |
| adr_i | input | ADDR_W | Byte address |
| sel_i | input | 4 | Byte enables |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Interrupt request (pending flag) |
| pin_i | input | N_PINS | Pin input levels |
| ext_clk_i | input | 1 | External sampling clock, asynchronous |
| aux_i | input | N_PINS | Auxiliary output sources |
| pin_o | output | N_PINS | Pin output values |
| pin_oe_no | output | N_PINS | Per-pin output enable, active low |

## Verification
Two functions can act on the pending flag in the same cycle: a control write that clears it, and a pin trigger that is still live and enabled. The bench keeps a pin at its trigger level with the global enable on, then writes the control register with the enable kept and the pending bit at zero. The bench expects irq_o low in the cycle right after the write edge and high again one cycle later. The same structure is checked when the write also drops the enable: the request must then stay low.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W = 32;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_OE   = 3'd2,
    REG_IEN  = 3'd3,
    REG_POL  = 3'd4,
    REG_ALT  = 3'd5,
    REG_CTRL = 3'd6
  } reg_idx_e;

  localparam int CTRL_EXT  = 0;
  localparam int CTRL_FALL = 1;
  localparam int CTRL_IEN  = 2;
  localparam int CTRL_PEND = 3;

  typedef struct packed {
    logic irq_pend;
    logic irq_en;
    logic fall_sel;
    logic ext_sel;
  } ctrl_t;
endpackage

// File: rtl/gpio_port_sampler.sv
module gpio_port_sampler #(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              ext_clk_i,
  input  logic              ext_sel_i,
  input  logic              fall_sel_i,
  output logic [N_PINS-1:0] in_o
);
  // sync chain plus one history stage for edge detection
  logic [SYNC_STAGES:0] sh_q;
  logic                 rise, fall, load;
  logic [N_PINS-1:0]    in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  always_comb begin
    if (!ext_sel_i)     load = 1'b1;
    else if (fall_sel_i) load = fall;
    else                load = rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_q <= '0;
    else if (load) in_q <= pin_i;
  end

  assign in_o = in_q;

  a_r4_bus_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_sel_i |=> in_q == $past(pin_i));
  a_r5_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && !rise && !fall) |=> $stable(in_q));
  a_r6_rise_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && fall_sel_i && rise) |=> $stable(in_q));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int N_PINS = 32
) (
  input  logic [N_PINS-1:0] in_i,
  input  logic [N_PINS-1:0] ien_i,
  input  logic [N_PINS-1:0] pol_i,
  output logic              hit_o
);
  logic [N_PINS-1:0] hit_vec;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign hit_vec[i] = ien_i[i] & (in_i[i] ~^ pol_i[i]);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int N_PINS     = 32,
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [3:0]        sel_i,
  input  logic [BUS_W-1:0]  dat_i,
  output logic [BUS_W-1:0]  dat_o,
  output logic              ack_o,
  input  logic [N_PINS-1:0] in_i,
  input  logic              hit_i,
  output logic [N_PINS-1:0] out_o,
  output logic [N_PINS-1:0] oe_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] alt_o,
  output ctrl_t             ctrl_o
);
  logic [IDX_W-1:0]  idx;
  logic              access, wr_en, wr_ctrl;
  logic              ack_q;
  logic [BUS_W-1:0]  rd_mux, dat_q;
  logic [N_PINS-1:0] out_q, oe_q, ien_q, pol_q, alt_q;
  ctrl_t             ctrl_q;
  logic              unused_bus;

  assign idx        = adr_i[ADDR_SHIFT +: IDX_W];
  assign access     = cyc_i & stb_i & ~ack_q;
  assign wr_en      = access & we_i & (&sel_i);
  assign wr_ctrl    = wr_en & (idx == REG_CTRL);
  assign unused_bus = ^{adr_i, dat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
      ien_q <= '0;
      pol_q <= '0;
      alt_q <= '0;
    end else if (wr_en) begin
      case (reg_idx_e'(idx))
        REG_OUT: out_q <= dat_i[N_PINS-1:0];
        REG_OE:  oe_q  <= dat_i[N_PINS-1:0];
        REG_IEN: ien_q <= dat_i[N_PINS-1:0];
        REG_POL: pol_q <= dat_i[N_PINS-1:0];
        REG_ALT: alt_q <= dat_i[N_PINS-1:0];
        default: ;
      endcase
    end
  end

  // control write wins over a same-cycle trigger; a live level re-sets next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.ext_sel  <= dat_i[CTRL_EXT];
      ctrl_q.fall_sel <= dat_i[CTRL_FALL];
      ctrl_q.irq_en   <= dat_i[CTRL_IEN];
      ctrl_q.irq_pend <= ctrl_q.irq_pend & dat_i[CTRL_PEND];
    end else if (ctrl_q.irq_en && hit_i) begin
      ctrl_q.irq_pend <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_idx_e'(idx))
      REG_IN:   rd_mux[N_PINS-1:0] = in_i;
      REG_OUT:  rd_mux[N_PINS-1:0] = out_q;
      REG_OE:   rd_mux[N_PINS-1:0] = oe_q;
      REG_IEN:  rd_mux[N_PINS-1:0] = ien_q;
      REG_POL:  rd_mux[N_PINS-1:0] = pol_q;
      REG_ALT:  rd_mux[N_PINS-1:0] = alt_q;
      REG_CTRL: rd_mux[3:0]        = ctrl_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= access;
      if (access && !we_i) dat_q <= rd_mux;
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign out_o  = out_q;
  assign oe_o   = oe_q;
  assign ien_o  = ien_q;
  assign pol_o  = pol_q;
  assign alt_o  = alt_q;
  assign ctrl_o = ctrl_q;

  a_r2_ack_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access |=> ack_o);
  a_r3_partial_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && we_i && !(&sel_i) && idx == REG_OUT) |=> $stable(out_q));
  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !dat_i[CTRL_PEND]) |=> !ctrl_q.irq_pend);
  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.irq_pend) |-> $past(ctrl_q.irq_en));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int ADDR_W      = 8,
  parameter int ADDR_SHIFT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [3:0]        sel_i,
  input  logic [31:0]       dat_i,
  output logic [31:0]       dat_o,
  output logic              ack_o,
  output logic              irq_o,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              ext_clk_i,
  input  logic [N_PINS-1:0] aux_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_no
);
  logic [N_PINS-1:0] in_val, out_val, oe_val, ien_val, pol_val, alt_val;
  logic              hit;
  ctrl_t             ctrl;

  gpio_port_regs #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .in_i(in_val), .hit_i(hit), .out_o(out_val), .oe_o(oe_val),
    .ien_o(ien_val), .pol_o(pol_val), .alt_o(alt_val), .ctrl_o(ctrl)
  );

  gpio_port_sampler #(
    .N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .ext_clk_i(ext_clk_i),
    .ext_sel_i(ctrl.ext_sel), .fall_sel_i(ctrl.fall_sel), .in_o(in_val)
  );

  gpio_port_irq #(.N_PINS(N_PINS)) u_irq (
    .in_i(in_val), .ien_i(ien_val), .pol_i(pol_val), .hit_o(hit)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_out
    assign pin_o[i]     = alt_val[i] ? aux_i[i] : out_val[i];
    assign pin_oe_no[i] = ~oe_val[i];
  end

  assign irq_o = ctrl.irq_pend;

  a_r9_irq_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hit));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int SH = 2;
  localparam logic [31:0] MASK = (32'h1 << N) - 1;

  logic clk = 0, rst_n = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [7:0] adr = '0;
  logic [3:0] sel = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic ack, irq, ext_clk = 0;
  logic [N-1:0] pins = '0, aux = '0, pout, poe_n;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.N_PINS(N), .ADDR_W(8), .ADDR_SHIFT(SH)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .adr_i(adr), .sel_i(sel), .dat_i(wdat), .dat_o(rdat), .ack_o(ack),
    .irq_o(irq), .pin_i(pins), .ext_clk_i(ext_clk), .aux_i(aux),
    .pin_o(pout), .pin_oe_no(poe_n)
  );

  function automatic logic [31:0] exp_out(input logic [31:0] o, a, x);
    return ((x & a) | (o & ~a)) & MASK;
  endfunction

  function automatic logic exp_hit(input logic [31:0] p, ien, pol);
    return |(ien & ~(p ^ pol) & MASK);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int idx, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 8'(idx << SH); wdat = d; sel = s;
    @(posedge clk);
    @(negedge clk);
    chk("R2 write ack", 32'(ack), 32'd1);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 8'(idx << SH); sel = 4'hf;
    @(posedge clk);
    @(negedge clk);
    chk("R2 read ack", 32'(ack), 32'd1);
    d = rdat;
    cyc = 0; stb = 0;
  endtask

  task automatic ext_to(input logic v);
    @(negedge clk);
    ext_clk = v;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, a, b, o, al, ie, po;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R12 reset state
    chk("R12 oe_n after reset", 32'(poe_n), MASK);
    chk("R12 pin_o after reset", 32'(pout), 32'd0);
    chk("R12 irq after reset", 32'(irq), 32'd0);
    for (int i = 1; i < 7; i++) begin
      bus_rd(i, r);
      chk("R12 register zero", r, 32'd0);
    end
    @(posedge clk); @(negedge clk);
    chk("R2 ack single cycle", 32'(ack), 32'd0);

    // R1 map, masking, hole
    bus_wr(1, 32'hffff_ffff, 4'hf);
    bus_rd(1, r);
    chk("R1 bits above width read zero", r, MASK);
    for (int i = 2; i < 6; i++) bus_wr(i, 32'h100 * i + 32'h11, 4'hf);
    for (int i = 2; i < 6; i++) begin
      bus_rd(i, r);
      chk("R1 register readback", r, (32'h100 * i + 32'h11) & MASK);
    end
    bus_rd(7, r);
    chk("R1 index 7 reads zero", r, 32'd0);
    bus_wr(3, 32'd0, 4'hf);
    bus_wr(5, 32'd0, 4'hf);

    // R3 partial byte enables
    bus_wr(1, 32'h0000_0a5a, 4'hf);
    bus_wr(1, 32'h0000_0123, 4'b0111);
    bus_rd(1, r);
    chk("R3 partial write ignored", r, 32'h0000_0a5a);
    chk("R3 pin_o unchanged", 32'(pout), 32'h0000_0a5a);

    // R7 output enable
    for (int k = 0; k < 6; k++) begin
      a = $urandom;
      bus_wr(2, a, 4'hf);
      chk("R7 oe_n complement", 32'(poe_n), ~a & MASK);
    end

    // R8 aux steering, random plus all-alt / no-alt corners
    for (int k = 0; k < 10; k++) begin
      o = $urandom; al = $urandom; b = $urandom;
      if (k == 0) al = 32'hffff_ffff;
      if (k == 1) al = 32'h0;
      aux = b[N-1:0];
      bus_wr(5, al, 4'hf);
      bus_wr(1, o, 4'hf);
      chk("R8 pin_o mux", 32'(pout), exp_out(o, al, b));
    end

    // R4 bus-clock sampling
    bus_wr(6, 32'd0, 4'hf);
    for (int k = 0; k < 8; k++) begin
      a = $urandom;
      pins = a[N-1:0];
      bus_rd(0, r);
      chk("R4 input follows pins", r, a & MASK);
    end

    // R5 rising-edge capture
    pins = 12'h0f0;
    bus_wr(6, 32'h1, 4'hf);
    ext_to(1'b1);
    bus_rd(0, r);
    chk("R5 rising edge captures", r, 32'h0f0);
    pins = 12'h3c3;
    repeat (6) @(posedge clk);
    bus_rd(0, r);
    chk("R5 idle clock holds", r, 32'h0f0);
    ext_to(1'b0);
    bus_rd(0, r);
    chk("R5 falling edge ignored", r, 32'h0f0);
    ext_to(1'b1);
    bus_rd(0, r);
    chk("R5 second rising edge", r, 32'h3c3);

    // R6 falling-edge capture
    bus_wr(6, 32'h3, 4'hf);
    pins = 12'h5a5;
    ext_to(1'b0);
    bus_rd(0, r);
    chk("R6 falling edge captures", r, 32'h5a5);
    pins = 12'ha5a;
    ext_to(1'b1);
    bus_rd(0, r);
    chk("R6 rising edge ignored", r, 32'h5a5);
    ext_to(1'b0);
    bus_rd(0, r);
    chk("R6 next falling edge", r, 32'ha5a);

    // R9 / R11 level interrupts with random enable and polarity
    for (int k = 0; k < 8; k++) begin
      int p;
      bus_wr(6, 32'd0, 4'hf);
      ie = $urandom & MASK; po = $urandom & MASK;
      p = int'($urandom % N);
      ie[p] = 1'b1;
      pins = N'(~po);
      bus_wr(3, ie, 4'hf);
      bus_wr(4, po, 4'hf);
      pins[p] = po[p];
      repeat (3) @(posedge clk); @(negedge clk);
      chk("R11 no request while disabled", 32'(irq), 32'd0);
      pins = N'(~po);
      repeat (3) @(posedge clk);
      bus_wr(6, 32'h4, 4'hf);
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R9 quiet when no pin matches", 32'(irq), 32'(exp_hit(32'(pins), ie, po)));
      pins[p] = po[p];
      repeat (2) @(posedge clk); @(negedge clk);
      chk("R9 request within two clocks", 32'(irq), 32'd1);
      bus_wr(6, 32'd0, 4'hf);
      chk("R10 write zero clears", 32'(irq), 32'd0);
      repeat (3) @(posedge clk); @(negedge clk);
      chk("R11 stays low after disable", 32'(irq), 32'd0);
    end

    // R10 collision: clear write with live trigger, enable kept
    bus_wr(6, 32'h4, 4'hf);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R9 request before collision", 32'(irq), 32'd1);
    bus_wr(6, 32'h4 | 32'h8, 4'hf);
    chk("R10 writing one keeps pending", 32'(irq), 32'd1);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 8'(6 << SH); wdat = 32'h4; sel = 4'hf;
    @(posedge clk); @(negedge clk);
    chk("R10 clear wins same cycle", 32'(irq), 32'd0);
    cyc = 0; stb = 0; we = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 live trigger re-sets", 32'(irq), 32'd1);
    bus_wr(6, 32'd0, 4'hf);
    chk("R10 clear with enable off", 32'(irq), 32'd0);
    bus_wr(6, 32'h8, 4'hf);
    chk("R10 writing one cannot set", 32'(irq), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule